// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block is the digital supervisor that turns a sustained output short into a repeating off/retry cycle instead of continuous current limiting. It watches two flags from analog comparators: one raised while the switch current limit is acting, and one raised while the feedback voltage sits under 70% of the reference. A fault counts only while both are up together. The fault must be held across a qualification window measured in microsecond ticks before the block acts.

Once the fault qualifies, the block forces both power switches off and asks the compensation and soft-start nodes to be discharged. It holds that state for a fixed number of switching-clock cycles. It then releases the switches for a restart window of fixed length. Inside that window the fault cannot trigger a new shutdown. At the end of the window the block samples the fault once. If the fault is gone it returns to normal operation. If the fault is still there it goes straight back to the off state. Dropping the enable input returns the block to idle from any state and clears every counter.

Top module: `hiccup_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sw_off`, `comp_discharge`, `ss_discharge` and `retry_window` are all 0.
- R2: The fault is `ilim_active` and `fb_low` both at 1. In normal operation, hiccup starts on the 36th `us_tick` sampled while the fault has been held without a break. `sw_off` is 1 from the clock edge that samples that tick. After 35 such ticks `sw_off` is still 0.
- R3: If either `ilim_active` or `fb_low` is 0 for one clock, the tick count clears. A further full 36 ticks are then needed.
- R4: In the off state, `sw_off`, `comp_discharge` and `ss_discharge` are 1 and `retry_window` is 0.
- R5: The off state lasts exactly 896 clock cycles. The restart window follows at once and lasts exactly 112 clock cycles. In the restart window `retry_window` is 1 and the other three outputs are 0.
- R6: During the restart window the fault and ticks are ignored. The window runs its full 112 cycles even with the fault held and ticks arriving.
- R7: In the last restart cycle the fault is sampled. If it is present, the off state is entered again at the next edge. If it is absent, normal operation resumes with all four outputs 0.
- R8: `enable` at 0 sends the block to idle at the next edge, with all outputs 0 and all counters cleared. After re-enable, a fresh 36 ticks are needed to trip.
- R9: With the fault held and no `us_tick`, the block never trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Device enable; low forces idle |
| ilim_active | input | 1 | Current limit is acting |
| fb_low | input | 1 | Feedback below 70% of the reference |
| us_tick | input | 1 | One-clock pulse each microsecond |
| sw_off | output | 1 | Force both power switches off |
| comp_discharge | output | 1 | Pull the compensation node low |
| ss_discharge | output | 1 | Pull the soft-start node low |
| retry_window | output | 1 | Restart attempt in progress |

## Verification
The hardest situation to reach is the decision at the end of the restart window. The bench must have crossed a qualification, a full 896-cycle off phase and a 112-cycle window, with the fault in a chosen state at exactly the last window cycle. The bench gets there with a directed run. It trips the block, times each phase by counting cycles at the ports, and keeps the fault and ticks active throughout the first window, so that both the blanking and the re-entry are exercised. It then clears the fault during the second off phase, so that the second window ends in normal operation.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_RUN   = 2'd1,
        HS_OFF   = 2'd2,
        HS_RETRY = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic sw_off;
        logic comp_dis;
        logic ss_dis;
        logic retry;
    } hs_ctl_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic hs_ctl_t decode_ctl(input hs_state_e s);
        hs_ctl_t c;
        c = '0;
        case (s)
            HS_OFF: begin
                c.sw_off   = 1'b1;
                c.comp_dis = 1'b1;
                c.ss_dis   = 1'b1;
            end
            HS_RETRY: c.retry = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hiccup_qual_timer.sv
module hiccup_qual_timer
    import hiccup_pkg::*;
#(
    parameter int unsigned QUAL_TICKS = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic fault,
    input  logic tick,
    output logic done
);
    localparam int unsigned W = cnt_w(QUAL_TICKS);
    localparam logic [W-1:0] LAST = W'(QUAL_TICKS - 1);

    logic [W-1:0] cnt;

    assign done = arm && fault && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm || !fault) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hiccup_phase_timer.sv
module hiccup_phase_timer
    import hiccup_pkg::*;
#(
    parameter int unsigned OFF_CYCLES   = 896,
    parameter int unsigned RETRY_CYCLES = 112
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sel_retry,
    output logic expire
);
    localparam int unsigned W = cnt_w(max2(OFF_CYCLES, RETRY_CYCLES));
    localparam logic [W-1:0] OFF_LAST   = W'(OFF_CYCLES - 1);
    localparam logic [W-1:0] RETRY_LAST = W'(RETRY_CYCLES - 1);

    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last   = sel_retry ? RETRY_LAST : OFF_LAST;
    assign expire = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hiccup_fsm.sv
module hiccup_fsm
    import hiccup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      qual_done,
    input  logic      phase_expire,
    input  logic      fault,
    output hs_state_e state
);
    hs_state_e nxt;

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = HS_IDLE;
        end else begin
            case (state)
                HS_IDLE:  nxt = HS_RUN;
                HS_RUN:   if (qual_done) nxt = HS_OFF;
                HS_OFF:   if (phase_expire) nxt = HS_RETRY;
                HS_RETRY: if (phase_expire) nxt = fault ? HS_OFF : HS_RUN;
                default:  nxt = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= HS_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
    import hiccup_pkg::*;
#(
    parameter int unsigned QUAL_TICKS   = 36,
    parameter int unsigned OFF_CYCLES   = 896,
    parameter int unsigned RETRY_CYCLES = 112
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ilim_active,
    input  logic fb_low,
    input  logic us_tick,
    output logic sw_off,
    output logic comp_discharge,
    output logic ss_discharge,
    output logic retry_window
);
    hs_state_e state;
    hs_ctl_t   ctl;
    logic      fault;
    logic      qual_done;
    logic      phase_expire;
    logic      arm;
    logic      run;

    assign fault = ilim_active && fb_low;
    assign arm   = enable && (state == HS_RUN);
    assign run   = enable && ((state == HS_OFF) || (state == HS_RETRY));

    hiccup_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) qual_i (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .fault (fault),
        .tick  (us_tick),
        .done  (qual_done)
    );

    hiccup_phase_timer #(
        .OFF_CYCLES   (OFF_CYCLES),
        .RETRY_CYCLES (RETRY_CYCLES)
    ) phase_i (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .sel_retry (state == HS_RETRY),
        .expire    (phase_expire)
    );

    hiccup_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .qual_done    (qual_done),
        .phase_expire (phase_expire),
        .fault        (fault),
        .state        (state)
    );

    assign ctl            = decode_ctl(state);
    assign sw_off         = ctl.sw_off;
    assign comp_discharge = ctl.comp_dis;
    assign ss_discharge   = ctl.ss_dis;
    assign retry_window   = ctl.retry;
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk #(
    parameter int unsigned OFF_CYCLES   = 896,
    parameter int unsigned RETRY_CYCLES = 112
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic ilim_active,
    input logic fb_low,
    input logic us_tick,
    input logic sw_off,
    input logic comp_discharge,
    input logic ss_discharge,
    input logic retry_window
);
    logic [31:0] off_len;
    logic [31:0] retry_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_len   <= '0;
            retry_len <= '0;
        end else begin
            off_len   <= sw_off ? off_len + 1 : '0;
            retry_len <= retry_window ? retry_len + 1 : '0;
        end
    end

    // R2: entry from normal operation needs fault plus tick one edge earlier
    a_r2_entry_needs_fault: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_off) && !$past(retry_window) |-> $past(ilim_active && fb_low && us_tick));

    // R5: off phase length
    a_r5_off_length: assert property (@(posedge clk) disable iff (rst)
        $past(enable) && $fell(sw_off) |-> off_len == OFF_CYCLES);

    // R5: restart window length
    a_r5_retry_length: assert property (@(posedge clk) disable iff (rst)
        $past(enable) && $fell(retry_window) |-> retry_len == RETRY_CYCLES);

    // R7: decision at end of restart window
    a_r7_retry_exit: assert property (@(posedge clk) disable iff (rst)
        $past(enable) && $fell(retry_window) |-> sw_off == $past(ilim_active && fb_low));

    // R8: disable forces idle outputs
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !(sw_off || comp_discharge || ss_discharge || retry_window));
endmodule

bind hiccup_guard hiccup_guard_chk #(
    .OFF_CYCLES   (OFF_CYCLES),
    .RETRY_CYCLES (RETRY_CYCLES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .ilim_active    (ilim_active),
    .fb_low         (fb_low),
    .us_tick        (us_tick),
    .sw_off         (sw_off),
    .comp_discharge (comp_discharge),
    .ss_discharge   (ss_discharge),
    .retry_window   (retry_window)
);

// File: tb/hiccup_guard_tb_top.sv
module hiccup_guard_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic ilim_active = 1'b0;
    logic fb_low = 1'b0;
    logic us_tick = 1'b0;
    logic sw_off, comp_discharge, ss_discharge, retry_window;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hiccup_guard dut_i (
        .clk(clk), .rst(rst), .enable(enable), .ilim_active(ilim_active),
        .fb_low(fb_low), .us_tick(us_tick), .sw_off(sw_off),
        .comp_discharge(comp_discharge), .ss_discharge(ss_discharge),
        .retry_window(retry_window)
    );

    typedef struct packed {
        logic       ilim;
        logic       fbl;
        logic [7:0] nt;
        logic       trip;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 1'b1, 8'd36, 1'b1},
        '{1'b1, 1'b1, 8'd35, 1'b0},
        '{1'b1, 1'b0, 8'd50, 1'b0},
        '{1'b0, 1'b1, 8'd50, 1'b0},
        '{1'b0, 1'b0, 8'd50, 1'b0},
        '{1'b1, 1'b1, 8'd40, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            repeat (3) @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    endtask

    task automatic restart(input logic il, input logic fl);
        enable = 1'b0;
        ilim_active = 1'b0;
        fb_low = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        ilim_active = il;
        fb_low = fl;
    endtask

    function automatic int outs();
        return {28'd0, sw_off, comp_discharge, ss_discharge, retry_window};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        enable = 1'b1; ilim_active = 1'b1; fb_low = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R1 outputs in reset", outs(), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", outs(), 0);

        // R2/R9 table walk
        for (int i = 0; i < 6; i++) begin
            restart(VEC[i].ilim, VEC[i].fbl);
            tick_n(int'(VEC[i].nt));
            chk($sformatf("R2 vector %0d sw_off", i), int'(sw_off), int'(VEC[i].trip));
        end

        // R9: fault held without ticks
        restart(1'b1, 1'b1);
        repeat (300) @(negedge clk);
        chk("R9 no ticks no trip", outs(), 0);

        // R3: one-cycle drop clears the count
        restart(1'b1, 1'b1);
        tick_n(30);
        fb_low = 1'b0;
        @(negedge clk);
        fb_low = 1'b1;
        tick_n(35);
        chk("R3 35 ticks after drop", int'(sw_off), 0);
        tick_n(1);
        chk("R3 36 ticks after drop", int'(sw_off), 1);

        // R4: off state outputs
        chk("R4 off outputs", outs(), 4'b1110);

        // R5: off length
        n = 0;
        while (sw_off && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk("R5 off cycles", n, 896);
        chk("R5 retry outputs", outs(), 4'b0001);

        // R6: blanked restart window with fault and ticks
        n = 0;
        while (retry_window && n < 2000) begin
            n++;
            us_tick = (n % 4 == 0);
            @(negedge clk);
        end
        us_tick = 1'b0;
        chk("R6 retry cycles with fault", n, 112);
        chk("R7 fault present re-enters off", outs(), 4'b1110);

        // R7: fault cleared during off, returns to normal
        ilim_active = 1'b0;
        n = 0;
        while (sw_off && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk("R5 second off cycles", n, 896);
        n = 0;
        while (retry_window && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk("R5 second retry cycles", n, 112);
        chk("R7 fault cleared normal", outs(), 0);
        repeat (20) @(negedge clk);
        chk("R7 stays normal", outs(), 0);

        // R8: disable during off
        ilim_active = 1'b1;
        tick_n(36);
        chk("R8 trip before disable", int'(sw_off), 1);
        repeat (100) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 disable idle", outs(), 0);
        @(negedge clk);
        enable = 1'b1;
        tick_n(35);
        chk("R8 35 ticks after re-enable", int'(sw_off), 0);
        tick_n(1);
        chk("R8 36 ticks after re-enable", int'(sw_off), 1);

        // R8: disable during qualification clears the count
        restart(1'b1, 1'b1);
        tick_n(20);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        tick_n(20);
        chk("R8 qual cleared by disable", int'(sw_off), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule